// File: doc/BRIEF.md
# Register Rename History Buffer

This block records every destination-register rename made by a small out-of-order core, so that each rename can later be either retired or undone. Each hardware thread has its own ordered list of records. A record holds the sequence number of the renaming instruction, the architectural register, the physical register just assigned, and the physical register that mapping replaced.

Records enter through an allocate port, one per renamed destination. The commit port retires the oldest record of a thread and emits a free strobe carrying the replaced physical register, which the free list reclaims. The squash port carries a thread and a sequence number. It starts a walk from the youngest record of that thread. Each undone record emits a restore strobe, which gives the map table the architectural register and its previous physical register and gives the free list the physical register that is now unused.

Top module: `rename_history_buf`

## Requirements
- R1: After reset every list is empty, `alloc_ready_o` is high, and `squash_busy_o`, `commit_free_valid_o`, `commit_err_o` and `restore_valid_o` are low.
- R2: A record is stored when `alloc_valid_i` and `alloc_ready_o` are both high. `alloc_ready_o` is low while the list of the thread on `alloc_tid_i` holds DEPTH records. An offered record is never dropped or overwritten.
- R3: A commit whose sequence number equals that of the thread's oldest record removes that record. On the next cycle it pulses `commit_free_valid_o`, with `commit_free_preg_o` set to the record's previous physical register.
- R4: A commit on an empty list, or one whose sequence number differs from the oldest record's, pulses `commit_err_o` on the next cycle. It removes nothing and produces no free strobe.
- R5: Each thread's list is independent. Allocating, committing or squashing on one thread neither changes nor stalls another thread's records.
- R6: A squash raises `squash_busy_o` on the next cycle. Each following cycle undoes one record, youngest first, while that record's sequence number is greater (unsigned, no wrap) than the squash sequence number. Each undone record gives one `restore_valid_o` pulse carrying the thread, the architectural register, the previous physical register (`restore_preg_o`) and the new physical register (`reclaim_preg_o`).
- R7: The walk ends in the cycle when the youngest remaining record is not younger than the squash point, or the list is empty. `squash_busy_o` then falls with no restore strobe. Records at or older than the squash point stay in place.
- R8: When a commit and a squash walk step touch the same thread in one cycle, the commit is applied first. A record retired by that commit is never restored.
- R9: `alloc_ready_o` is low while `squash_busy_o` is high, and no record enters any list during a walk.
- R10: A squash request that arrives while a walk is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_valid_i | input | 1 | Offer a rename record |
| alloc_tid_i | input | TID_W | Thread of the offered record |
| alloc_seq_i | input | SEQ_W | Sequence number of the renaming instruction |
| alloc_arch_i | input | ARCH_W | Architectural destination register |
| alloc_new_i | input | PHYS_W | Physical register just assigned |
| alloc_prev_i | input | PHYS_W | Physical register previously mapped |
| alloc_ready_o | output | 1 | Record can be accepted |
| commit_valid_i | input | 1 | Retire the oldest record of a thread |
| commit_tid_i | input | TID_W | Thread to retire from |
| commit_seq_i | input | SEQ_W | Sequence number expected at the oldest end |
| squash_valid_i | input | 1 | Start a squash walk |
| squash_tid_i | input | TID_W | Thread to squash |
| squash_seq_i | input | SEQ_W | Squash point; younger records are undone |
| squash_busy_o | output | 1 | Squash walk in progress |
| commit_free_valid_o | output | 1 | Free strobe from a commit |
| commit_free_preg_o | output | PHYS_W | Previous physical register to release |
| commit_err_o | output | 1 | Commit did not match the oldest record |
| restore_valid_o | output | 1 | One record undone |
| restore_tid_o | output | TID_W | Thread of the undone record |
| restore_arch_o | output | ARCH_W | Architectural register to restore |
| restore_preg_o | output | PHYS_W | Physical register to map back |
| reclaim_preg_o | output | PHYS_W | Physical register to return to the free list |

## Verification
On every cycle the assertions check these rules: a restore strobe only follows a busy cycle, allocation is closed during a walk, each commit request yields exactly one free or error pulse, a squash request from idle always starts a walk, and free and error never coincide. The bench scenarios have to show the data: that the right previous and new registers come out in youngest-first order, that the walk stops at the squash point and leaves older records alone, and that a stalled or ignored request left no trace in the lists. They also show the commit-before-squash ordering on a shared last record and the independence of the threads.

// File: rtl/rhb_pkg.sv
package rhb_pkg;
  localparam int unsigned DEF_THREADS = 2;
  localparam int unsigned DEF_DEPTH   = 8;
  localparam int unsigned DEF_SEQ_W   = 8;
  localparam int unsigned DEF_ARCH_W  = 5;
  localparam int unsigned DEF_PHYS_W  = 6;

  typedef enum logic {
    SQ_IDLE = 1'b0,
    SQ_WALK = 1'b1
  } sq_state_e;
endpackage

// File: rtl/rhb_hist_fifo.sv
// Per-thread record list: push at young end, pop at either end.
module rhb_hist_fifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned REC_W = 25,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = AW + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [REC_W-1:0] push_rec_i,
  input  logic             pop_old_i,
  input  logic             pop_young_i,
  output logic [CW-1:0]    count_o,
  output logic [REC_W-1:0] oldest_o,
  output logic [REC_W-1:0] youngest_o
);
  logic [REC_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]    rd_ptr_q, wr_ptr_q, last_ptr;
  logic [CW-1:0]    cnt_q;

  assign last_ptr   = wr_ptr_q - 1'b1;
  assign oldest_o   = mem_q[rd_ptr_q];
  assign youngest_o = mem_q[last_ptr];
  assign count_o    = cnt_q;

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_ptr_q] <= push_rec_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (pop_old_i) rd_ptr_q <= rd_ptr_q + 1'b1;
      // push and young pop never coincide: walk closes allocation
      if (push_i)           wr_ptr_q <= wr_ptr_q + 1'b1;
      else if (pop_young_i) wr_ptr_q <= last_ptr;
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_old_i) - CW'(pop_young_i);
    end
  end
endmodule

// File: rtl/rhb_commit_unit.sv
// Retires the oldest record of one thread (R3, R4).
module rhb_commit_unit #(
  parameter int unsigned NUM_THREADS = 2,
  parameter int unsigned SEQ_W       = 8,
  parameter int unsigned ARCH_W      = 5,
  parameter int unsigned PHYS_W      = 6,
  parameter int unsigned CW          = 4,
  localparam int unsigned TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int unsigned REC_W      = SEQ_W + ARCH_W + 2 * PHYS_W
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               commit_valid_i,
  input  logic [TID_W-1:0]                   commit_tid_i,
  input  logic [SEQ_W-1:0]                   commit_seq_i,
  input  logic [NUM_THREADS-1:0][CW-1:0]     cnt_i,
  input  logic [NUM_THREADS-1:0][REC_W-1:0]  oldest_i,
  output logic [NUM_THREADS-1:0]             pop_old_o,
  output logic                               free_valid_o,
  output logic [PHYS_W-1:0]                  free_preg_o,
  output logic                               err_o
);
  typedef struct packed {
    logic [SEQ_W-1:0]  seq;
    logic [ARCH_W-1:0] arch;
    logic [PHYS_W-1:0] new_p;
    logic [PHYS_W-1:0] prev_p;
  } rec_t;

  rec_t head;
  logic match;

  assign head  = rec_t'(oldest_i[commit_tid_i]);
  assign match = (cnt_i[commit_tid_i] != '0) && (head.seq == commit_seq_i);

  always_comb begin
    pop_old_o = '0;
    if (commit_valid_i && match) pop_old_o[commit_tid_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      free_valid_o <= 1'b0;
      free_preg_o  <= '0;
      err_o        <= 1'b0;
    end else begin
      free_valid_o <= commit_valid_i && match;
      free_preg_o  <= head.prev_p;
      err_o        <= commit_valid_i && !match;
    end
  end
endmodule

// File: rtl/rhb_squash_walk.sv
// Undo walk, youngest record first, one per cycle (R6, R7, R8, R10).
module rhb_squash_walk
  import rhb_pkg::*;
#(
  parameter int unsigned NUM_THREADS = 2,
  parameter int unsigned SEQ_W       = 8,
  parameter int unsigned ARCH_W      = 5,
  parameter int unsigned PHYS_W      = 6,
  parameter int unsigned CW          = 4,
  localparam int unsigned TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int unsigned REC_W      = SEQ_W + ARCH_W + 2 * PHYS_W
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               squash_valid_i,
  input  logic [TID_W-1:0]                   squash_tid_i,
  input  logic [SEQ_W-1:0]                   squash_seq_i,
  input  logic [NUM_THREADS-1:0][CW-1:0]     cnt_i,
  input  logic [NUM_THREADS-1:0][REC_W-1:0]  youngest_i,
  input  logic [NUM_THREADS-1:0]             pop_old_i,
  output logic [NUM_THREADS-1:0]             pop_young_o,
  output logic                               busy_o,
  output logic                               restore_valid_o,
  output logic [TID_W-1:0]                   restore_tid_o,
  output logic [ARCH_W-1:0]                  restore_arch_o,
  output logic [PHYS_W-1:0]                  restore_preg_o,
  output logic [PHYS_W-1:0]                  reclaim_preg_o
);
  typedef struct packed {
    logic [SEQ_W-1:0]  seq;
    logic [ARCH_W-1:0] arch;
    logic [PHYS_W-1:0] new_p;
    logic [PHYS_W-1:0] prev_p;
  } rec_t;

  sq_state_e        state_q;
  logic [TID_W-1:0] tid_q;
  logic [SEQ_W-1:0] seq_q;
  rec_t             tail;
  logic [CW-1:0]    eff_cnt;
  logic             step;

  assign tail    = rec_t'(youngest_i[tid_q]);
  // commit of this cycle is seen first (R8)
  assign eff_cnt = cnt_i[tid_q] - CW'(pop_old_i[tid_q]);
  assign step    = (state_q == SQ_WALK) && (eff_cnt != '0) && (tail.seq > seq_q);
  assign busy_o  = (state_q == SQ_WALK);

  always_comb begin
    pop_young_o = '0;
    if (step) pop_young_o[tid_q] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q         <= SQ_IDLE;
      tid_q           <= '0;
      seq_q           <= '0;
      restore_valid_o <= 1'b0;
      restore_tid_o   <= '0;
      restore_arch_o  <= '0;
      restore_preg_o  <= '0;
      reclaim_preg_o  <= '0;
    end else begin
      restore_valid_o <= step;
      restore_tid_o   <= tid_q;
      restore_arch_o  <= tail.arch;
      restore_preg_o  <= tail.prev_p;
      reclaim_preg_o  <= tail.new_p;
      case (state_q)
        SQ_IDLE: if (squash_valid_i) begin
          state_q <= SQ_WALK;
          tid_q   <= squash_tid_i;
          seq_q   <= squash_seq_i;
        end
        SQ_WALK: if (!step) state_q <= SQ_IDLE;  // R7
        default: state_q <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rename_history_buf.sv
module rename_history_buf
  import rhb_pkg::*;
#(
  parameter int unsigned NUM_THREADS = DEF_THREADS,
  parameter int unsigned DEPTH       = DEF_DEPTH,
  parameter int unsigned SEQ_W       = DEF_SEQ_W,
  parameter int unsigned ARCH_W      = DEF_ARCH_W,
  parameter int unsigned PHYS_W      = DEF_PHYS_W,
  localparam int unsigned TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int unsigned REC_W      = SEQ_W + ARCH_W + 2 * PHYS_W,
  localparam int unsigned CW         = $clog2(DEPTH) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_valid_i,
  input  logic [TID_W-1:0]  alloc_tid_i,
  input  logic [SEQ_W-1:0]  alloc_seq_i,
  input  logic [ARCH_W-1:0] alloc_arch_i,
  input  logic [PHYS_W-1:0] alloc_new_i,
  input  logic [PHYS_W-1:0] alloc_prev_i,
  output logic              alloc_ready_o,
  input  logic              commit_valid_i,
  input  logic [TID_W-1:0]  commit_tid_i,
  input  logic [SEQ_W-1:0]  commit_seq_i,
  input  logic              squash_valid_i,
  input  logic [TID_W-1:0]  squash_tid_i,
  input  logic [SEQ_W-1:0]  squash_seq_i,
  output logic              squash_busy_o,
  output logic              commit_free_valid_o,
  output logic [PHYS_W-1:0] commit_free_preg_o,
  output logic              commit_err_o,
  output logic              restore_valid_o,
  output logic [TID_W-1:0]  restore_tid_o,
  output logic [ARCH_W-1:0] restore_arch_o,
  output logic [PHYS_W-1:0] restore_preg_o,
  output logic [PHYS_W-1:0] reclaim_preg_o
);
  logic [NUM_THREADS-1:0][CW-1:0]    cnt;
  logic [NUM_THREADS-1:0][REC_W-1:0] oldest, youngest;
  logic [NUM_THREADS-1:0]            push, pop_old, pop_young;
  logic [REC_W-1:0]                  new_rec;
  logic                              accept;

  // R2, R9: stall on a full target list or during a walk
  assign alloc_ready_o = !squash_busy_o && (cnt[alloc_tid_i] != CW'(DEPTH));
  assign accept        = alloc_valid_i && alloc_ready_o;
  assign new_rec       = {alloc_seq_i, alloc_arch_i, alloc_new_i, alloc_prev_i};

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    assign push[t] = accept && (alloc_tid_i == TID_W'(t));

    rhb_hist_fifo #(
      .DEPTH (DEPTH),
      .REC_W (REC_W)
    ) u_fifo (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .push_i      (push[t]),
      .push_rec_i  (new_rec),
      .pop_old_i   (pop_old[t]),
      .pop_young_i (pop_young[t]),
      .count_o     (cnt[t]),
      .oldest_o    (oldest[t]),
      .youngest_o  (youngest[t])
    );
  end

  rhb_commit_unit #(
    .NUM_THREADS (NUM_THREADS),
    .SEQ_W       (SEQ_W),
    .ARCH_W      (ARCH_W),
    .PHYS_W      (PHYS_W),
    .CW          (CW)
  ) u_commit (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .commit_valid_i (commit_valid_i),
    .commit_tid_i   (commit_tid_i),
    .commit_seq_i   (commit_seq_i),
    .cnt_i          (cnt),
    .oldest_i       (oldest),
    .pop_old_o      (pop_old),
    .free_valid_o   (commit_free_valid_o),
    .free_preg_o    (commit_free_preg_o),
    .err_o          (commit_err_o)
  );

  rhb_squash_walk #(
    .NUM_THREADS (NUM_THREADS),
    .SEQ_W       (SEQ_W),
    .ARCH_W      (ARCH_W),
    .PHYS_W      (PHYS_W),
    .CW          (CW)
  ) u_squash (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .squash_valid_i  (squash_valid_i),
    .squash_tid_i    (squash_tid_i),
    .squash_seq_i    (squash_seq_i),
    .cnt_i           (cnt),
    .youngest_i      (youngest),
    .pop_old_i       (pop_old),
    .pop_young_o     (pop_young),
    .busy_o          (squash_busy_o),
    .restore_valid_o (restore_valid_o),
    .restore_tid_o   (restore_tid_o),
    .restore_arch_o  (restore_arch_o),
    .restore_preg_o  (restore_preg_o),
    .reclaim_preg_o  (reclaim_preg_o)
  );
endmodule

// File: rtl/rhb_checker.sv
module rhb_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic alloc_ready_o,
  input logic commit_valid_i,
  input logic squash_valid_i,
  input logic squash_busy_o,
  input logic commit_free_valid_o,
  input logic commit_err_o,
  input logic restore_valid_o
);
  assert_commit_answer_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_valid_i |=> (commit_free_valid_o || commit_err_o));

  assert_no_spurious_free_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_valid_i |=> !(commit_free_valid_o || commit_err_o));

  assert_free_err_excl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(commit_free_valid_o && commit_err_o));

  assert_squash_starts_walk_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (squash_valid_i && !squash_busy_o) |=> squash_busy_o);

  assert_restore_in_walk_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_valid_o |-> $past(squash_busy_o));

  assert_walk_rise_cause_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(squash_busy_o) |-> $past(squash_valid_i));

  assert_alloc_closed_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash_busy_o |-> !alloc_ready_o);
endmodule

bind rename_history_buf rhb_checker u_rhb_chk (
  .clk_i               (clk_i),
  .rst_ni              (rst_ni),
  .alloc_ready_o       (alloc_ready_o),
  .commit_valid_i      (commit_valid_i),
  .squash_valid_i      (squash_valid_i),
  .squash_busy_o       (squash_busy_o),
  .commit_free_valid_o (commit_free_valid_o),
  .commit_err_o        (commit_err_o),
  .restore_valid_o     (restore_valid_o)
);

// File: tb/sim_rename_history_buf.sv
module sim_rename_history_buf;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       alloc_valid_i = 1'b0;
  logic       alloc_tid_i = 1'b0;
  logic [7:0] alloc_seq_i = '0;
  logic [4:0] alloc_arch_i = '0;
  logic [5:0] alloc_new_i = '0, alloc_prev_i = '0;
  logic       alloc_ready_o;
  logic       commit_valid_i = 1'b0;
  logic       commit_tid_i = 1'b0;
  logic [7:0] commit_seq_i = '0;
  logic       squash_valid_i = 1'b0;
  logic       squash_tid_i = 1'b0;
  logic [7:0] squash_seq_i = '0;
  logic       squash_busy_o, commit_free_valid_o, commit_err_o, restore_valid_o;
  logic       restore_tid_o;
  logic [5:0] commit_free_preg_o, restore_preg_o, reclaim_preg_o;
  logic [4:0] restore_arch_o;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rename_history_buf u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .alloc_valid_i(alloc_valid_i), .alloc_tid_i(alloc_tid_i), .alloc_seq_i(alloc_seq_i),
    .alloc_arch_i(alloc_arch_i), .alloc_new_i(alloc_new_i), .alloc_prev_i(alloc_prev_i),
    .alloc_ready_o(alloc_ready_o),
    .commit_valid_i(commit_valid_i), .commit_tid_i(commit_tid_i), .commit_seq_i(commit_seq_i),
    .squash_valid_i(squash_valid_i), .squash_tid_i(squash_tid_i), .squash_seq_i(squash_seq_i),
    .squash_busy_o(squash_busy_o),
    .commit_free_valid_o(commit_free_valid_o), .commit_free_preg_o(commit_free_preg_o),
    .commit_err_o(commit_err_o),
    .restore_valid_o(restore_valid_o), .restore_tid_o(restore_tid_o),
    .restore_arch_o(restore_arch_o), .restore_preg_o(restore_preg_o),
    .reclaim_preg_o(reclaim_preg_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic alloc(input logic tid, input int seq, input int arch, input int nw, input int pv);
    alloc_valid_i = 1'b1; alloc_tid_i = tid; alloc_seq_i = 8'(seq);
    alloc_arch_i = 5'(arch); alloc_new_i = 6'(nw); alloc_prev_i = 6'(pv);
    #1;
    chk("R2", "ready before push", int'(alloc_ready_o), 1);
    tick();
    alloc_valid_i = 1'b0;
  endtask

  task automatic commit(input string req, input logic tid, input int seq, input bit ok, input int preg);
    commit_valid_i = 1'b1; commit_tid_i = tid; commit_seq_i = 8'(seq);
    tick();
    commit_valid_i = 1'b0;
    chk(req, "free valid", int'(commit_free_valid_o), int'(ok));
    chk(req, "error", int'(commit_err_o), int'(!ok));
    if (ok) chk(req, "free preg", int'(commit_free_preg_o), preg);
  endtask

  task automatic expect_restore(input string req, input int seq);
    chk(req, "restore valid", int'(restore_valid_o), 1);
    chk(req, "restore tid", int'(restore_tid_o), 1);
    chk(req, "restore arch", int'(restore_arch_o), seq + 10);
    chk(req, "restore preg", int'(restore_preg_o), seq - 2);
    chk(req, "reclaim preg", int'(reclaim_preg_o), seq + 30);
  endtask

  task automatic t_reset();
    chk("R1", "ready", int'(alloc_ready_o), 1);
    chk("R1", "busy", int'(squash_busy_o), 0);
    chk("R1", "free", int'(commit_free_valid_o), 0);
    chk("R1", "err", int'(commit_err_o), 0);
    chk("R1", "restore", int'(restore_valid_o), 0);
  endtask

  // R2 R3 R4 R5: fill thread 0, stall, ordered retire
  task automatic t_fill_commit();
    for (int i = 1; i <= 8; i++) alloc(1'b0, i, i, 16 + i, i);
    alloc_valid_i = 1'b1; alloc_tid_i = 1'b0; alloc_seq_i = 8'd9; alloc_prev_i = 6'd63;
    #1;
    chk("R2", "ready on full list", int'(alloc_ready_o), 0);
    tick();
    alloc_valid_i = 1'b0; alloc_tid_i = 1'b1;
    #1;
    chk("R5", "other thread ready", int'(alloc_ready_o), 1);
    commit("R3", 1'b0, 1, 1'b1, 1);
    commit("R4", 1'b0, 5, 1'b0, 0);
    commit("R4", 1'b0, 2, 1'b1, 2);
    for (int i = 3; i <= 8; i++) commit("R3", 1'b0, i, 1'b1, i);
    commit("R2", 1'b0, 9, 1'b0, 0);
    commit("R4", 1'b0, 8, 1'b0, 0);
  endtask

  // R6 R7 R9 R10 R5: walk stops at squash point
  task automatic t_squash();
    for (int s = 10; s <= 13; s++) alloc(1'b1, s, s + 10, s + 30, s - 2);
    alloc(1'b0, 12, 1, 50, 3);
    squash_valid_i = 1'b1; squash_tid_i = 1'b1; squash_seq_i = 8'd11;
    tick();
    chk("R6", "busy after request", int'(squash_busy_o), 1);
    chk("R6", "no restore yet", int'(restore_valid_o), 0);
    squash_seq_i = 8'd9;  // R10: ignored second request
    alloc_valid_i = 1'b1; alloc_tid_i = 1'b1; alloc_seq_i = 8'd12;
    alloc_arch_i = 5'd0; alloc_new_i = 6'd0; alloc_prev_i = 6'd0;
    #1;
    chk("R9", "ready during walk", int'(alloc_ready_o), 0);
    tick();
    squash_valid_i = 1'b0;
    expect_restore("R6", 13);
    tick();
    alloc_valid_i = 1'b0;
    expect_restore("R6", 12);
    tick();
    chk("R7", "busy ends", int'(squash_busy_o), 0);
    chk("R10", "no restore past point", int'(restore_valid_o), 0);
    tick();
    chk("R7", "still idle", int'(restore_valid_o), 0);
    commit("R7", 1'b1, 10, 1'b1, 8);
    commit("R7", 1'b1, 11, 1'b1, 9);
    commit("R9", 1'b1, 12, 1'b0, 0);
    commit("R5", 1'b0, 12, 1'b1, 3);
  endtask

  // R8: commit retires the last record in the walk cycle
  task automatic t_same_cycle();
    alloc(1'b0, 60, 7, 60, 30);
    squash_valid_i = 1'b1; squash_tid_i = 1'b0; squash_seq_i = 8'd55;
    tick();
    squash_valid_i = 1'b0;
    chk("R8", "busy", int'(squash_busy_o), 1);
    commit_valid_i = 1'b1; commit_tid_i = 1'b0; commit_seq_i = 8'd60;
    tick();
    commit_valid_i = 1'b0;
    chk("R8", "free valid", int'(commit_free_valid_o), 1);
    chk("R8", "free preg", int'(commit_free_preg_o), 30);
    chk("R8", "no restore", int'(restore_valid_o), 0);
    chk("R8", "busy ends", int'(squash_busy_o), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    #1;
    t_reset();
    tick();
    t_fill_commit();
    t_squash();
    t_same_cycle();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule